// File: doc/BRIEF.md
# Dual Down-Counting Timer with Shared Interrupt

This block contains two independent programmable timers and one interrupt line. Each timer holds a reload value, a live count and a small control word. Software loads the count from the reload value and starts it with a single control write. The count then steps down and reloads itself each time it expires. Every expiry latches a pending bit for that timer.

The pending bits pass through an enable mask. The registered interrupt output is the OR of the masked pending bits. Software clears pending bits by writing ones to an acknowledge location. The line falls only once no enabled pending bit is left.

A reload value above a fixed threshold switches that timer to a slow rate, where it steps once every few clocks. A watchdog control location accepts writes that change nothing. The block is accessed through a 32-bit word port with a combinational read.

Top module: `dual_timer_irq`

## Requirements
- R1: After reset, every readable location returns zero and `irq_out` is low.
- R2: A control write whose bits [1:0] equal 0 (load) copies the timer's reload value into its count in the same cycle. With control bit 2 (enable) set, the count then decreases by one per clock. The count is readable at timer base + 0x04 and the reload value at base + 0x00, with timer 0 at base 0x00 and timer 1 at base 0x10.
- R3: When a count step finds the count at 1 or 0, the timer expires: its count is reloaded from the reload value and its pending bit is set in the same edge. Timer 0 uses pending bit 0 and timer 1 uses bit 1. With reload value D (D ≥ 1), expiry comes D clocks after the load edge; with D = 0 it comes every clock.
- R4: `irq_out` is registered. It is high in exactly the cycles where the pending bits ANDed with the mask are nonzero, and it changes on the same edge as the pending or mask register.
- R5: The mask at 0x48 is read/write over bits [1:0]. The raw pending bits read at 0x50, and the pending bits ANDed with the mask read at 0x54.
- R6: A write to 0x4C clears each pending bit that is 1 in the written value. An expiry on the same edge keeps its bit set. `irq_out` stays high while any other enabled pending bit remains.
- R7: When the reload value is greater than 2048, the count steps once every 4 clocks. A reload value of exactly 2048 counts at the full rate.
- R8: Control bits [1:0] equal to 1 hold the count, and equal to 2 resume counting from the held value without a reload. Code 3 also holds. With control bit 2 clear the count never changes.
- R9: A write to the watchdog control location 0x40 changes no state. The locations 0x40, 0x38, 0x4C and all unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 8 | Byte offset of the word; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Interrupt request, high while any enabled pending bit is set |

## Verification
The hardest case to reach from the ports is the slow counting rate. It needs a reload value past the threshold, so expiry comes only after more than eight thousand clocks. The stimulus loads 2050 and then 2048 and measures the exact clock distance to the interrupt in each case.

A second hard case is an acknowledge that lands on the same edge as a fresh expiry. The stimulus reaches it by loading a reload value of zero, which makes the timer expire every clock, so any acknowledge coincides with an expiry. A behavioural model runs beside the design and is compared against the output and the addressed word on every clock.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int unsigned REG_W = 32;

  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_HOLD   = 2'd1,
    OP_RESUME = 2'd2,
    OP_SPARE  = 2'd3
  } tmr_op_e;

  typedef struct packed {
    logic    en;
    tmr_op_e op;
  } tmr_ctrl_t;

  localparam int unsigned CTRL_W = $bits(tmr_ctrl_t);

  localparam logic [7:0] OFF_RELOAD = 8'h00;
  localparam logic [7:0] OFF_COUNT  = 8'h04;
  localparam logic [7:0] OFF_CTRL   = 8'h08;
  localparam int unsigned TMR_STRIDE = 16;
  localparam logic [7:0] OFF_WDOG   = 8'h40;
  localparam logic [7:0] OFF_MASK   = 8'h48;
  localparam logic [7:0] OFF_ACK    = 8'h4C;
  localparam logic [7:0] OFF_RAW    = 8'h50;
  localparam logic [7:0] OFF_MRAW   = 8'h54;
endpackage

// File: rtl/dtmr_counter.sv
module dtmr_counter
  import dtmr_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned PRE_DIV     = 4,
  parameter int unsigned SLOW_THRESH = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload_we,
  input  logic              ctrl_we,
  input  logic [REG_W-1:0]  wdata,
  output logic [CNT_W-1:0]  reload_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              expire_o
);
  localparam int unsigned   PS_W    = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRE_DIV - 1);

  logic [CNT_W-1:0] reload_q, reload_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  tmr_ctrl_t        ctrl_q, ctrl_d;
  logic [PS_W-1:0]  ps_q, ps_d;
  logic             load, running, slow, tick, expire;

  always_comb begin
    load    = ctrl_we && (tmr_op_e'(wdata[1:0]) == OP_LOAD);
    running = ctrl_q.en && ((ctrl_q.op == OP_LOAD) || (ctrl_q.op == OP_RESUME));
    slow    = reload_q > CNT_W'(SLOW_THRESH);
    tick    = running && (!slow || (ps_q == PS_LAST));
    expire  = tick && !load && (cnt_q <= CNT_W'(1));

    reload_d = reload_we ? wdata[CNT_W-1:0] : reload_q;
    ctrl_d   = ctrl_we ? tmr_ctrl_t'(wdata[CTRL_W-1:0]) : ctrl_q;

    ps_d = ps_q;
    if (load) begin
      ps_d = '0;
    end else if (running && slow) begin
      ps_d = (ps_q == PS_LAST) ? '0 : ps_q + PS_W'(1);
    end

    cnt_d = cnt_q;
    if (load) begin
      cnt_d = reload_q;
    end else if (expire) begin
      cnt_d = reload_q;
    end else if (tick) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
      ctrl_q   <= '0;
      ps_q     <= '0;
    end else begin
      reload_q <= reload_d;
      cnt_q    <= cnt_d;
      ctrl_q   <= ctrl_d;
      ps_q     <= ps_d;
    end
  end

  assign reload_o = reload_q;
  assign count_o  = cnt_q;
  assign ctrl_o   = ctrl_q;
  assign expire_o = expire;

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(reload_q))); // R2
  AST_RELOAD_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == $past(reload_q))); // R3
  AST_HALT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load) |=> $stable(cnt_q)); // R8
  AST_SLOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && slow && (ps_q != PS_LAST) && !load) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/dtmr_irq_ctl.sv
module dtmr_irq_ctl #(
  parameter int unsigned NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mask_we,
  input  logic               ack_we,
  input  logic [NUM_SRC-1:0] wdata,
  input  logic [NUM_SRC-1:0] expire,
  output logic [NUM_SRC-1:0] raw_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] raw_q, raw_d;
  logic [NUM_SRC-1:0] mask_q, mask_d;
  logic [NUM_SRC-1:0] clr;
  logic               irq_q, irq_d;

  always_comb begin
    clr    = ack_we ? wdata : '0;
    raw_d  = (raw_q & ~clr) | expire;
    mask_d = mask_we ? wdata : mask_q;
    irq_d  = |(raw_d & mask_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
      irq_q  <= irq_d;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> ((raw_q & mask_q) != '0)); // R4
  AST_IRQ_FALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_q) |-> ((raw_q & mask_q) == '0)); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we |=> ((raw_q & $past(wdata & ~expire)) == '0)); // R6
  AST_EXPIRY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire != '0) |=> ((raw_q & $past(expire)) == $past(expire))); // R3
endmodule

// File: rtl/dual_timer_irq.sv
module dual_timer_irq
  import dtmr_pkg::*;
#(
  parameter int unsigned NUM_TMR     = 2,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned PRE_DIV     = 4,
  parameter int unsigned SLOW_THRESH = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_out
);
  logic [7:0]         waddr;
  logic [CNT_W-1:0]   reload_w [NUM_TMR];
  logic [CNT_W-1:0]   count_w  [NUM_TMR];
  logic [CTRL_W-1:0]  ctrl_w   [NUM_TMR];
  logic [NUM_TMR-1:0] expire_w;
  logic [NUM_TMR-1:0] raw_w, mask_w;
  logic               mask_we, ack_we, wdog_we;

  assign waddr   = {bus_addr[7:2], 2'b00};
  assign mask_we = bus_we && (waddr == OFF_MASK);
  assign ack_we  = bus_we && (waddr == OFF_ACK);
  assign wdog_we = bus_we && (waddr == OFF_WDOG);

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    localparam logic [7:0] BASE = 8'(g * TMR_STRIDE);
    logic reload_we, ctrl_we;
    assign reload_we = bus_we && (waddr == BASE + OFF_RELOAD);
    assign ctrl_we   = bus_we && (waddr == BASE + OFF_CTRL);

    dtmr_counter #(
      .CNT_W      (CNT_W),
      .PRE_DIV    (PRE_DIV),
      .SLOW_THRESH(SLOW_THRESH)
    ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .reload_we(reload_we),
      .ctrl_we  (ctrl_we),
      .wdata    (bus_wdata),
      .reload_o (reload_w[g]),
      .count_o  (count_w[g]),
      .ctrl_o   (ctrl_w[g]),
      .expire_o (expire_w[g])
    );
  end

  dtmr_irq_ctl #(.NUM_SRC(NUM_TMR)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .mask_we(mask_we),
    .ack_we (ack_we),
    .wdata  (bus_wdata[NUM_TMR-1:0]),
    .expire (expire_w),
    .raw_o  (raw_w),
    .mask_o (mask_w),
    .irq_o  (irq_out)
  );

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (waddr == 8'(i * TMR_STRIDE) + OFF_RELOAD) bus_rdata = 32'(reload_w[i]);
      if (waddr == 8'(i * TMR_STRIDE) + OFF_COUNT)  bus_rdata = 32'(count_w[i]);
      if (waddr == 8'(i * TMR_STRIDE) + OFF_CTRL)   bus_rdata = 32'(ctrl_w[i]);
    end
    if (waddr == OFF_MASK) bus_rdata = 32'(mask_w);
    if (waddr == OFF_RAW)  bus_rdata = 32'(raw_w);
    if (waddr == OFF_MRAW) bus_rdata = 32'(raw_w & mask_w);
  end

  AST_WDOG_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_we |=> ($stable(mask_w) && $stable(reload_w[0]))); // R9
endmodule

// File: tb/dual_timer_irq_test.sv
`timescale 1ns/1ps
module dual_timer_irq_test;
  localparam int PRE = 4;
  localparam int THR = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h04;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [7:0]  watch = 8'h04;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          cmp_on = 1'b0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  dual_timer_irq uut (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_out(irq)
  );

  // behavioural reference
  logic [31:0] m_rel [2];
  logic [31:0] m_cnt [2];
  logic [2:0]  m_ctl [2];
  int          m_ps  [2];
  logic [1:0]  m_raw, m_mask;
  logic        m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < 2; t++) begin
        m_rel[t] = 0; m_cnt[t] = 0; m_ctl[t] = 0; m_ps[t] = 0;
      end
      m_raw = 0; m_mask = 0; m_irq = 0;
    end else begin
      logic [1:0] fired;
      fired = 0;
      for (int t = 0; t < 2; t++) begin
        bit run, slow, stepping;
        int base;
        base = t * 16;
        run = m_ctl[t][2] && (m_ctl[t][1:0] == 0 || m_ctl[t][1:0] == 2);
        slow = m_rel[t] > THR;
        stepping = run && (!slow || m_ps[t] == PRE - 1);
        if (we && addr == 8'(base + 8) && wdata[1:0] == 0) begin
          m_cnt[t] = m_rel[t];
          m_ps[t] = 0;
        end else begin
          if (run && slow) m_ps[t] = (m_ps[t] + 1) % PRE;
          if (stepping) begin
            if (m_cnt[t] <= 1) begin
              fired[t] = 1'b1;
              m_cnt[t] = m_rel[t];
            end else m_cnt[t] = m_cnt[t] - 1;
          end
        end
        if (we && addr == 8'(base)) m_rel[t] = wdata;
        if (we && addr == 8'(base + 8)) m_ctl[t] = wdata[2:0];
      end
      if (we && addr == 8'h4C) m_raw = m_raw & ~wdata[1:0];
      m_raw = m_raw | fired;
      if (we && addr == 8'h48) m_mask = wdata[1:0];
      m_irq = |(m_raw & m_mask);
    end
  end

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h00: return m_rel[0];
      8'h04: return m_cnt[0];
      8'h08: return 32'(m_ctl[0]);
      8'h10: return m_rel[1];
      8'h14: return m_cnt[1];
      8'h18: return 32'(m_ctl[1]);
      8'h48: return 32'(m_mask);
      8'h50: return 32'(m_raw);
      8'h54: return 32'(m_raw & m_mask);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] a);
    if (a == 8'h48 || a == 8'h50 || a == 8'h54) return "R5";
    if (a < 8'h20) return "R2";
    return "R9";
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check(rdata == m_read(addr), tag_of(addr), "model rdata", rdata, m_read(addr));
      check(irq == m_irq, "R4", "model irq_out", irq, m_irq);
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0; addr = watch;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    addr = a;
    @(negedge clk);
    check(rdata == exp, tag, "read", rdata, exp);
    addr = watch;
  endtask

  task automatic measure(int limit, output int n);
    n = 0;
    @(negedge clk);
    while (!irq && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic idle(int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired R1 actual=hung expected=done");
    finish_run();
  end

  initial begin
    int n;
    logic [31:0] held;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cmp_on = 1'b1;
    // R1 reset state
    rd(8'h00, 0, "R1"); rd(8'h04, 0, "R1"); rd(8'h08, 0, "R1");
    rd(8'h14, 0, "R1"); rd(8'h48, 0, "R1"); rd(8'h50, 0, "R1");
    check(irq == 1'b0, "R1", "irq after reset", irq, 0);

    // R2 load and count
    wr(8'h48, 32'h1);
    wr(8'h00, 32'd5);
    wr(8'h08, 32'h4);
    rd(8'h04, 32'd5, "R2");
    rd(8'h04, 32'd4, "R2");
    // R3 expiry distance
    wr(8'h08, 32'h4);
    measure(100, n);
    check(n == 5, "R3", "clocks to expiry", n, 5);
    rd(8'h50, 32'h1, "R3");

    // R6 two sources, partial ack
    wr(8'h48, 32'h3);
    wr(8'h10, 32'd7);
    wr(8'h18, 32'h4);
    idle(20);
    wr(8'h08, 32'h5);
    wr(8'h18, 32'h5);
    rd(8'h50, 32'h3, "R3");
    rd(8'h54, 32'h3, "R5");
    wr(8'h4C, 32'h1);
    rd(8'h50, 32'h2, "R6");
    check(irq == 1'b1, "R6", "irq held by other bit", irq, 1);
    wr(8'h4C, 32'h2);
    rd(8'h50, 32'h0, "R6");
    check(irq == 1'b0, "R6", "irq after full ack", irq, 0);

    // R8 hold, resume, disable
    addr = 8'h04; @(negedge clk); held = rdata;
    idle(10);
    rd(8'h04, held, "R8");
    wr(8'h08, 32'h6);
    idle(2);
    addr = 8'h04; @(negedge clk);
    check(rdata != held, "R8", "count moves after resume", rdata, held);
    wr(8'h08, 32'h2);
    addr = 8'h04; @(negedge clk); held = rdata;
    idle(10);
    rd(8'h04, held, "R8");

    // R4/R5 masked off
    wr(8'h48, 32'h0);
    wr(8'h00, 32'd3);
    wr(8'h08, 32'h4);
    idle(10);
    wr(8'h08, 32'h1);
    rd(8'h50, 32'h1, "R5");
    rd(8'h54, 32'h0, "R5");
    check(irq == 1'b0, "R4", "irq while masked", irq, 0);
    wr(8'h48, 32'h1);
    check(irq == 1'b1, "R4", "irq after unmask", irq, 1);

    // R9 watchdog and unused
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h48, 32'h1, "R9");
    rd(8'h40, 32'h0, "R9");
    rd(8'h38, 32'h0, "R9");
    rd(8'h4C, 32'h0, "R9");
    rd(8'h00, 32'd3, "R9");

    // R3 zero reload, R6 ack racing expiry
    wr(8'h4C, 32'h3);
    wr(8'h00, 32'd0);
    wr(8'h08, 32'h4);
    measure(100, n);
    check(n == 1, "R3", "zero reload expiry", n, 1);
    wr(8'h4C, 32'h1);
    rd(8'h50, 32'h1, "R6");
    check(irq == 1'b1, "R6", "irq with racing expiry", irq, 1);

    // R7 slow rate
    wr(8'h08, 32'h0);
    wr(8'h4C, 32'h3);
    wr(8'h48, 32'h2);
    watch = 8'h14;
    wr(8'h10, 32'd2050);
    wr(8'h18, 32'h4);
    measure(20000, n);
    check(n == 2050 * PRE, "R7", "slow expiry distance", n, 2050 * PRE);
    wr(8'h18, 32'h1);
    wr(8'h4C, 32'h3);
    wr(8'h10, 32'd2048);
    wr(8'h18, 32'h4);
    measure(20000, n);
    check(n == 2048, "R7", "threshold expiry distance", n, 2048);
    idle(3);
    finish_run();
  end
endmodule